// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs a chain of I2C messages on top of a byte-level master engine. The engine raises an event together with an 8-bit status code each time a bus phase completes. The sequencer answers every event with exactly one write to the engine's control word. Where the phase calls for it, a byte also goes to the engine's data register. Messages arrive as descriptors on a valid/ready stream. Each descriptor carries a 10-bit target address, a read/write direction, a flag that selects 10-bit addressing, a byte count and a flag that marks the last message of the transfer.

Bytes to be written are taken from a valid/ready input stream. Bytes read from the target are delivered on a valid/ready output stream. Between two messages the sequencer issues a repeated start. At the end of the transfer it sends a stop and pulses `done` with a result code. An engine reset is requested on any status the sequencer does not expect. A whole-transfer timeout and an optional settling hold are counted in clock cycles.

Top module: `i2c_msg_seq`

## Requirements
- R1: The first address byte is {addr[6:0], rd} for 7-bit messages and {4'b1111, 1'b0, addr[9:8], rd} for 10-bit messages. The second address byte of a 10-bit message is addr[7:0].
- R2: In idle, with no event pending, a descriptor is accepted and the control word 0xE4 is written. The control word fields are: bit 7 event enable, bit 6 engine enable, bit 5 start, bit 4 stop, bit 2 acknowledge.
- R3: Status 0x08 (start) or 0x10 (repeated start) writes the first address byte and then the continue word. The continue word is 0xC4 while acknowledge is kept, and 0xC0 once it is withdrawn.
- R4: Status 0x18 or 0x40 on a 10-bit message writes the second address byte plus the continue word. Status 0xD0 and 0xE0 then act as the write and read address acknowledges.
- R5: On a write acknowledge (0x18 for 7-bit, 0xD0, 0x28) with bytes left, one byte is taken from the write stream and written, followed by the continue word. The sequencer waits while the stream is empty. With no bytes left it writes the stop word 0x50 and reports result 0 on the last message, and otherwise writes 0xE4 for the next descriptor.
- R6: On a read address acknowledge (0x40 for 7-bit, 0xE0) with zero bytes, the stop word and result 0 are issued. Otherwise the continue word is written, with acknowledge withdrawn when exactly one byte remains. Status 0x50 delivers one byte and 0x58 delivers the final byte and stops. Neither moves until the read stream is ready.
- R7: Status 0x20, 0x30 or 0x48 writes the stop word and reports result 1 (no device).
- R8: Any other status in a transfer pulses the engine reset, writes the stop word and reports result 2 (bus error).
- R9: An event that arrives while idle is answered with the stop word alone, and no `done`.
- R10: After a repeated start and after the stop that ends a read, the sequencer holds HOLD_CYC cycles. During the hold it makes no control write and accepts no descriptor. The next action therefore comes HOLD_CYC+2 cycles after that write at the earliest.
- R11: Once a transfer has lasted TIMEOUT_CYC cycles, the sequencer pulses the engine reset, writes the stop word and reports result 2. This takes precedence over a pending event in the same cycle.
- R12: `done` is a one-cycle pulse that comes only with the stop word 0x50, which has the event enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken |
| desc_addr | input | 10 | Target address |
| desc_rd | input | 1 | 1 = read message |
| desc_ten | input | 1 | 1 = 10-bit address |
| desc_len | input | LEN_W | Byte count |
| desc_last | input | 1 | Last message of the transfer |
| evt_valid | input | 1 | Engine event pending |
| evt_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine received byte |
| ctl_we | output | 1 | Control word write strobe |
| ctl_wdata | output | 8 | Control word |
| dat_we | output | 1 | Data register write strobe |
| dat_wdata | output | 8 | Byte to transmit |
| eng_rst | output | 1 | Engine reset request |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer finished pulse |
| result | output | 2 | 0 ok, 1 no device, 2 bus error |

## Verification
The timeout expiry and an engine status can fall in the same cycle. In that case the expiry must win. The bench provokes this by raising a write acknowledge while the write stream is empty, so the event stays pending until the transfer time runs out. It then expects the engine reset, the stop word and result 2 together, with no data byte written and nothing taken from the write stream.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_NEXT = 2'd2,
    S_HOLD = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NODEV  = 2'd1,
    RES_BUSERR = 2'd2
  } seq_res_e;

  // control word fields decoded by the engine
  localparam int unsigned CB_ACK   = 2;
  localparam int unsigned CB_STOP  = 4;
  localparam int unsigned CB_START = 5;
  localparam int unsigned CB_EN    = 6;
  localparam int unsigned CB_IEN   = 7;

  localparam logic [7:0] CTL_START = 8'hE4;
  localparam logic [7:0] CTL_STOP  = 8'h50;

  // engine status codes
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RESTART  = 8'h10;
  localparam logic [7:0] ST_WA_ACK   = 8'h18;
  localparam logic [7:0] ST_WA_NAK   = 8'h20;
  localparam logic [7:0] ST_WD_ACK   = 8'h28;
  localparam logic [7:0] ST_WD_NAK   = 8'h30;
  localparam logic [7:0] ST_RA_ACK   = 8'h40;
  localparam logic [7:0] ST_RA_NAK   = 8'h48;
  localparam logic [7:0] ST_RD_ACK   = 8'h50;
  localparam logic [7:0] ST_RD_NAK   = 8'h58;
  localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

  function automatic logic [7:0] ctl_cont(input logic ack);
    return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ack, 2'b00};
  endfunction

endpackage

// File: rtl/i2c_msg_seq_addr.sv
module i2c_msg_seq_addr (
  input  logic [9:0] addr,
  input  logic       rd,
  input  logic       ten,
  output logic [7:0] first,
  output logic [7:0] second
);
  always_comb begin
    if (ten) begin
      first  = {4'b1111, 1'b0, addr[9:8], rd};
      second = addr[7:0];
    end else begin
      first  = {addr[6:0], rd};
      second = 8'h00;
    end
  end
endmodule

// File: rtl/i2c_msg_seq_timer.sv
module i2c_msg_seq_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt, cnt_nxt;

  assign hit = (cnt == CW'(LIMIT));

  always_comb begin
    cnt_nxt = cnt;
    if (clr)             cnt_nxt = '0;
    else if (run && !hit) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R11 / R10: the count saturates at its limit
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_msg_seq_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 300000000,
  parameter int unsigned HOLD_CYC    = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [9:0]       desc_addr,
  input  logic             desc_rd,
  input  logic             desc_ten,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_last,
  input  logic             evt_valid,
  input  logic [7:0]       evt_status,
  input  logic [7:0]       eng_rdata,
  output logic             ctl_we,
  output logic [7:0]       ctl_wdata,
  output logic             dat_we,
  output logic [7:0]       dat_wdata,
  output logic             eng_rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [1:0]       result
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_e st, st_nxt;
  seq_res_e   res;
  logic [9:0] m_addr;
  logic       m_rd, m_ten, m_last;
  logic [LEN_W-1:0] left, left_nxt;
  logic       ack, ack_nxt;
  logic       hret, hret_nxt;
  logic       ld, to_clr, to_hit, hold_go, hold_hit;
  logic       wr_step, rd_step;
  logic [7:0] a1, a2;

  i2c_msg_seq_addr u_addr (
    .addr(m_addr), .rd(m_rd), .ten(m_ten), .first(a1), .second(a2)
  );

  i2c_msg_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(to_clr), .run(st != S_IDLE), .hit(to_hit)
  );

  generate
    if (HOLD_CYC > 0) begin : g_hold
      i2c_msg_seq_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(hold_go), .run(st == S_HOLD), .hit(hold_hit)
      );
    end else begin : g_nohold
      assign hold_hit = 1'b1;
    end
  endgenerate

  assign result = res;

  always_comb begin
    st_nxt = st;  ld = 1'b0;  left_nxt = left;  ack_nxt = ack;  hret_nxt = hret;
    desc_ready = 1'b0;  ctl_we = 1'b0;  ctl_wdata = 8'h00;
    dat_we = 1'b0;  dat_wdata = 8'h00;  eng_rst = 1'b0;
    wr_ready = 1'b0;  rd_valid = 1'b0;  rd_data = eng_rdata;
    done = 1'b0;  res = RES_OK;  to_clr = 1'b0;  hold_go = 1'b0;
    wr_step = 1'b0;  rd_step = 1'b0;

    unique case (st)
      S_IDLE: begin
        if (evt_valid) begin
          ctl_we = 1'b1;  ctl_wdata = CTL_STOP;
        end else if (desc_valid) begin
          desc_ready = 1'b1;  ld = 1'b1;  left_nxt = desc_len;  ack_nxt = 1'b1;
          ctl_we = 1'b1;  ctl_wdata = CTL_START;  to_clr = 1'b1;
          st_nxt = S_WAIT;
        end
      end

      S_WAIT: begin
        if (to_hit) begin
          eng_rst = 1'b1;  ctl_we = 1'b1;  ctl_wdata = CTL_STOP;
          done = 1'b1;  res = RES_BUSERR;  st_nxt = S_IDLE;
        end else if (evt_valid) begin
          case (evt_status)
            ST_START, ST_RESTART: begin
              dat_we = 1'b1;  dat_wdata = a1;
              ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack);
            end
            ST_WA_ACK: begin
              if (m_ten) begin
                dat_we = 1'b1;  dat_wdata = a2;
                ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack);
              end else wr_step = 1'b1;
            end
            ST_WA2_ACK, ST_WD_ACK: wr_step = 1'b1;
            ST_RA_ACK: begin
              if (m_ten) begin
                dat_we = 1'b1;  dat_wdata = a2;
                ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack);
              end else rd_step = 1'b1;
            end
            ST_RA2_ACK: rd_step = 1'b1;
            ST_RD_ACK: begin
              rd_valid = 1'b1;
              if (rd_ready) begin
                left_nxt = left - 1'b1;
                ack_nxt  = (left_nxt != ONE);
                ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack_nxt);
              end
            end
            ST_RD_NAK: begin
              rd_valid = 1'b1;
              if (rd_ready) begin
                ctl_we = 1'b1;  ctl_wdata = CTL_STOP;  done = 1'b1;
                if (HOLD_CYC > 0) begin
                  hold_go = 1'b1;  hret_nxt = 1'b0;  st_nxt = S_HOLD;
                end else st_nxt = S_IDLE;
              end
            end
            ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
              ctl_we = 1'b1;  ctl_wdata = CTL_STOP;
              done = 1'b1;  res = RES_NODEV;  st_nxt = S_IDLE;
            end
            default: begin
              eng_rst = 1'b1;  ctl_we = 1'b1;  ctl_wdata = CTL_STOP;
              done = 1'b1;  res = RES_BUSERR;  st_nxt = S_IDLE;
            end
          endcase

          if (wr_step) begin
            if (left == '0) begin
              if (m_last) begin
                ctl_we = 1'b1;  ctl_wdata = CTL_STOP;  done = 1'b1;  st_nxt = S_IDLE;
              end else st_nxt = S_NEXT;
            end else if (wr_valid) begin
              wr_ready = 1'b1;  dat_we = 1'b1;  dat_wdata = wr_data;
              ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack);  left_nxt = left - 1'b1;
            end
          end

          if (rd_step) begin
            if (left == '0) begin
              ctl_we = 1'b1;  ctl_wdata = CTL_STOP;  done = 1'b1;  st_nxt = S_IDLE;
            end else begin
              ack_nxt = (left != ONE);
              ctl_we = 1'b1;  ctl_wdata = ctl_cont(ack_nxt);
            end
          end
        end
      end

      S_NEXT: begin
        if (to_hit) begin
          eng_rst = 1'b1;  ctl_we = 1'b1;  ctl_wdata = CTL_STOP;
          done = 1'b1;  res = RES_BUSERR;  st_nxt = S_IDLE;
        end else if (desc_valid) begin
          desc_ready = 1'b1;  ld = 1'b1;  left_nxt = desc_len;  ack_nxt = 1'b1;
          ctl_we = 1'b1;  ctl_wdata = CTL_START;
          if (HOLD_CYC > 0) begin
            hold_go = 1'b1;  hret_nxt = 1'b1;  st_nxt = S_HOLD;
          end else st_nxt = S_WAIT;
        end
      end

      S_HOLD: begin
        if (hold_hit) st_nxt = hret ? S_WAIT : S_IDLE;
      end

      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      left <= '0;
      ack  <= 1'b0;
      hret <= 1'b0;
    end else begin
      st   <= st_nxt;
      left <= left_nxt;
      ack  <= ack_nxt;
      hret <= hret_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= '0;
      m_rd   <= 1'b0;
      m_ten  <= 1'b0;
      m_last <= 1'b0;
    end else if (ld) begin
      m_addr <= desc_addr;
      m_rd   <= desc_rd;
      m_ten  <= desc_ten;
      m_last <= desc_last;
    end
  end

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |-> (ctl_we && ctl_wdata[CB_START] && !ctl_wdata[CB_STOP]));

  a_r5_wr_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (dat_we && ctl_we && evt_valid));

  a_r6_rd_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (evt_valid && (evt_status == ST_RD_ACK || evt_status == ST_RD_NAK)));

  a_r8_rst_buserr: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> (done && result == 2'd2));

  a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !done);

  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> (!ctl_we && !desc_ready));

  a_r11_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAIT || st == S_NEXT) && to_hit) |-> (eng_rst && !dat_we && !wr_ready));

  a_r12_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_we && ctl_wdata == CTL_STOP && !ctl_wdata[CB_IEN]));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned TMO   = 200;
  localparam int unsigned HOLD  = 3;

  localparam int K_RST = 0, K_DAT = 1, K_RD = 2, K_CTL = 3, K_DONE = 4;

  typedef struct { int k; int v; string r; } item_t;
  typedef struct packed {
    logic [9:0] a; logic rd; logic ten; logic [7:0] len; logic last;
  } dsc_t;

  logic clk = 1'b0;
  logic rst_n;
  logic desc_valid = 1'b0, desc_ready;
  logic [9:0] desc_addr = '0;
  logic desc_rd = 1'b0, desc_ten = 1'b0, desc_last = 1'b0;
  logic [LEN_W-1:0] desc_len = '0;
  logic evt_valid = 1'b0;
  logic [7:0] evt_status = 8'h00, eng_rdata = 8'h00;
  logic ctl_we, dat_we, eng_rst, wr_ready, rd_valid, done;
  logic [7:0] ctl_wdata, dat_wdata, rd_data;
  logic wr_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] result;

  item_t expq[$];
  dsc_t  dq[$];
  logic [7:0] wq[$];
  int tests = 0, fails = 0, cyc = 0, last_ctl = 0, prev_ctl = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_msg_seq #(.LEN_W(LEN_W), .TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_rd(desc_rd), .desc_ten(desc_ten), .desc_len(desc_len), .desc_last(desc_last),
    .evt_valid(evt_valid), .evt_status(evt_status), .eng_rdata(eng_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .eng_rst(eng_rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .result(result)
  );

  task automatic push(input int k, input int v, input string r);
    item_t it;
    it.k = k; it.v = v; it.r = r;
    expq.push_back(it);
  endtask

  task automatic check(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic cmp(input int k, input int v);
    item_t it;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected output (R9/R12)", k * 256 + v, -1);
    end else begin
      it = expq.pop_front();
      check(it.k == k && it.v == v, it.r, k * 256 + v, it.k * 256 + it.v);
    end
  endtask

  // stream feeders: inputs change only at the falling edge
  always @(negedge clk) begin
    desc_valid = (dq.size() != 0);
    if (desc_valid) {desc_addr, desc_rd, desc_ten, desc_len, desc_last} = dq[0];
    wr_valid = (wq.size() != 0);
    wr_data  = wr_valid ? wq[0] : 8'h00;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      cyc++;
      if (eng_rst) cmp(K_RST, 0);
      if (dat_we) cmp(K_DAT, int'(dat_wdata));
      if (rd_valid && rd_ready) cmp(K_RD, int'(rd_data));
      if (ctl_we) begin
        cmp(K_CTL, int'(ctl_wdata));
        prev_ctl = last_ctl;
        last_ctl = cyc;
      end
      if (done) cmp(K_DONE, int'(result));
      if (wr_valid && wr_ready) void'(wq.pop_front());
      if (desc_valid && desc_ready) void'(dq.pop_front());
    end
  end

  task automatic desc(input int a, input bit rd, input bit ten, input int len, input bit last);
    dsc_t d;
    d.a = 10'(a); d.rd = rd; d.ten = ten; d.len = 8'(len); d.last = last;
    dq.push_back(d);
  endtask

  task automatic wait_dq(input int n);
    while (dq.size() > n) @(negedge clk);
  endtask

  // engine model: hold the event until a control write answers it
  task automatic raise(input logic [7:0] s, input logic [7:0] rdat);
    bit got;
    evt_status = s; eng_rdata = rdat; evt_valid = 1'b1;
    got = 1'b0;
    while (!got) begin
      #1;
      got = ctl_we;
      if (!got) @(negedge clk);
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!ctl_we && !done && !desc_ready && !eng_rst, "R12 reset state",
          {ctl_we, done, desc_ready, eng_rst}, 0);
    @(negedge clk);

    // T1: 7-bit write, two bytes (R1 R2 R3 R5 R12)
    wq.push_back(8'h11); wq.push_back(8'h22);
    push(K_CTL, 'hE4, "R2 start word");
    desc('h50, 0, 0, 2, 1); wait_dq(0);
    push(K_DAT, 'hA0, "R1 7-bit write addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_DAT, 'h11, "R5 first byte"); push(K_CTL, 'hC4, "R5 continue");
    raise(8'h18, 8'h00);
    push(K_DAT, 'h22, "R5 second byte"); push(K_CTL, 'hC4, "R5 continue");
    raise(8'h28, 8'h00);
    push(K_CTL, 'h50, "R5 final stop"); push(K_DONE, 0, "R12 ok result");
    raise(8'h28, 8'h00);

    // T2: 10-bit read, two bytes, with read stall (R1 R4 R6)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h2A5, 1, 1, 2, 1); wait_dq(0);
    push(K_DAT, 'hF5, "R1 10-bit first byte"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_DAT, 'hA5, "R4 second addr byte"); push(K_CTL, 'hC4, "R4 continue");
    raise(8'h40, 8'h00);
    push(K_CTL, 'hC4, "R6 ack kept with two left");
    raise(8'hE0, 8'h00);
    push(K_RD, 'h3C, "R6 first read byte"); push(K_CTL, 'hC0, "R6 ack withdrawn");
    rd_ready = 1'b0;
    fork begin repeat (4) @(negedge clk); rd_ready = 1'b1; end join_none
    raise(8'h50, 8'h3C);
    push(K_RD, 'h7E, "R6 final byte"); push(K_CTL, 'h50, "R6 stop");
    push(K_DONE, 0, "R6 ok result");
    raise(8'h58, 8'h7E);

    // T3: address not acknowledged, plus hold after read stop (R7 R10)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h33, 0, 0, 1, 1); wait_dq(0);
    @(negedge clk);
    check(last_ctl - prev_ctl == int'(HOLD) + 2, "R10 hold after read stop",
          last_ctl - prev_ctl, HOLD + 2);
    push(K_DAT, 'h66, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_CTL, 'h50, "R7 stop"); push(K_DONE, 1, "R7 no device on 0x20");
    raise(8'h20, 8'h00);

    // T4: data not acknowledged (R7)
    wq.push_back(8'h44);
    push(K_CTL, 'hE4, "R2 start word");
    desc('h33, 0, 0, 1, 1); wait_dq(0);
    push(K_DAT, 'h66, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_DAT, 'h44, "R5 byte"); push(K_CTL, 'hC4, "R5 continue");
    raise(8'h18, 8'h00);
    push(K_CTL, 'h50, "R7 stop"); push(K_DONE, 1, "R7 no device on 0x30");
    raise(8'h30, 8'h00);

    // T5: read address not acknowledged (R7)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h33, 1, 0, 1, 1); wait_dq(0);
    push(K_DAT, 'h67, "R1 read addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_CTL, 'h50, "R7 stop"); push(K_DONE, 1, "R7 no device on 0x48");
    raise(8'h48, 8'h00);

    // T6: write then read through a repeated start (R5 R10 R6)
    wq.push_back(8'h5A);
    push(K_CTL, 'hE4, "R2 start word");
    desc('h1B, 0, 0, 1, 0); desc('h1B, 1, 0, 1, 1); wait_dq(1);
    push(K_DAT, 'h36, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_DAT, 'h5A, "R5 byte"); push(K_CTL, 'hC4, "R5 continue");
    raise(8'h18, 8'h00);
    push(K_CTL, 'hE4, "R5 repeated start");
    raise(8'h28, 8'h00);
    push(K_DAT, 'h37, "R3 addr after restart"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h10, 8'h00);
    check(last_ctl - prev_ctl == int'(HOLD) + 2, "R10 hold after restart",
          last_ctl - prev_ctl, HOLD + 2);
    push(K_CTL, 'hC0, "R6 single byte ack withdrawn");
    raise(8'h40, 8'h00);
    push(K_RD, 'h99, "R6 only byte"); push(K_CTL, 'h50, "R6 stop");
    push(K_DONE, 0, "R12 ok result");
    raise(8'h58, 8'h99);
    repeat (HOLD + 3) @(negedge clk);

    // T7: zero-length read and write (R6 R5)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h11, 1, 0, 0, 1); wait_dq(0);
    push(K_DAT, 'h23, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_CTL, 'h50, "R6 zero-length read stop"); push(K_DONE, 0, "R6 ok");
    raise(8'h40, 8'h00);
    push(K_CTL, 'hE4, "R2 start word");
    desc('h11, 0, 0, 0, 1); wait_dq(0);
    push(K_DAT, 'h22, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_CTL, 'h50, "R5 zero-length write stop"); push(K_DONE, 0, "R5 ok");
    raise(8'h18, 8'h00);

    // T8: unexpected status (R8)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h11, 0, 0, 1, 1); wait_dq(0);
    push(K_DAT, 'h22, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_RST, 0, "R8 engine reset"); push(K_CTL, 'h50, "R8 stop");
    push(K_DONE, 2, "R8 bus error");
    raise(8'h38, 8'h00);

    // T9: event while idle (R9)
    push(K_CTL, 'h50, "R9 idle stop");
    raise(8'hF8, 8'h00);
    repeat (3) @(negedge clk);

    // T10: 10-bit write (R4)
    wq.push_back(8'hC3);
    push(K_CTL, 'hE4, "R2 start word");
    desc('h3FF, 0, 1, 1, 1); wait_dq(0);
    push(K_DAT, 'hF6, "R1 10-bit write first byte"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_DAT, 'hFF, "R4 second addr byte"); push(K_CTL, 'hC4, "R4 continue");
    raise(8'h18, 8'h00);
    push(K_DAT, 'hC3, "R4 byte after 0xD0"); push(K_CTL, 'hC4, "R5 continue");
    raise(8'hD0, 8'h00);
    push(K_CTL, 'h50, "R5 stop"); push(K_DONE, 0, "R12 ok");
    raise(8'h28, 8'h00);

    // T11: timeout while a write ack waits for data (R11)
    push(K_CTL, 'hE4, "R2 start word");
    desc('h11, 0, 0, 1, 1); wait_dq(0);
    push(K_DAT, 'h22, "R1 addr"); push(K_CTL, 'hC4, "R3 continue");
    raise(8'h08, 8'h00);
    push(K_RST, 0, "R11 engine reset"); push(K_CTL, 'h50, "R11 stop");
    push(K_DONE, 2, "R11 bus error");
    raise(8'h18, 8'h00);

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R12 all expected outputs seen", expq.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule